// File: doc/BRIEF.md
# Service Request Mailbox Controller

This peripheral connects a host processor to a system-service engine through a small register file and a shared word buffer. The host first puts command bytes into the buffer. It then writes a control word that carries a 7-bit service opcode, a buffer word offset for the response, a request strobe and an optional completion-notify flag. The block takes the request and holds its busy flag high while an internal fixed-latency responder runs. The responder writes two response words into the buffer at the requested offset. Busy then clears.

When notify was requested, completion also raises an interrupt line. That line stays high until the host writes an all-zero word to a dedicated clear register. The host can end a running service early through an abort bit. The buffer is readable and writable by the host through byte enables, so a partial trailing word can be merged without touching the other bytes. Host writes are refused while a service is in progress, so the service's view of the buffer and its command fields cannot change under it.

Top module: `svcMailbox`

## Requirements
- R1: After reset the control word, the status word and `irq` all read 0.
- R2: Byte address 0x050 is the control word, 0x054 is the status word and 0x058 is the interrupt-clear register. Buffer word i (0 ≤ i < BUF_WORDS) sits at 0x800 + 4·i. A read of an unmapped address returns 0.
- R3: Control and status share a bit layout: request at bit 0, busy at bit 1, abort at bit 2, notify at bit 3. Control bits [22:16] hold the opcode and bits [31:23] hold the response word offset. An idle write with bit 0 set latches these fields. The control word then reads back the written word, with bit 0 = 1, for one cycle. In the next cycle bit 0 clears and busy rises.
- R4: Busy stays 1 for exactly LATENCY cycles (default 8) after a request is accepted.
- R5: On completion, buffer word `offset` holds the opcode zero-extended to 32 bits and word `offset+1` holds 2, the response word count. Both indices wrap modulo BUF_WORDS, and the other words are unchanged.
- R6: A buffer write changes only the byte lanes whose `regBe` bit is 1, and every buffer word reads back its current value.
- R7: From acceptance until busy clears, control writes that request a service are refused (the latched fields and the service outcome are unchanged), and buffer writes are ignored.
- R8: When notify was set, `irq` rises in the cycle busy falls. Status bit 3 mirrors `irq`. Without notify, `irq` stays 0.
- R9: `irq` stays 1 until a write of exactly 0 to the clear register. A nonzero write there leaves it set.
- R10: A control write with bit 2 set while busy clears busy in the next cycle, sets status abort and leaves the response words unwritten. It raises `irq` if notify was set. With no service running, the abort bit has no effect. The next accepted request clears the abort status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register/buffer write strobe |
| regAddr | input | 12 | Byte address |
| regWdata | input | 32 | Write data |
| regBe | input | 4 | Byte-lane enables for buffer writes |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| irq | output | 1 | Completion interrupt, level |

## Verification
The assertions check the handshake on every cycle. They cover the request bit clearing into busy, refusal of requests while busy, an abort ending busy with the abort flag set, `irq` holding until a zero clear, and `irq` rising only as busy falls. The bench scenarios are what show the data results: the exact busy length, the response words and their wraparound at the top of the buffer, byte-lane merging, buffer writes being ignored during a service, and buffer contents surviving an abort.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W     = 12;
  localparam int OP_W       = 7;
  localparam int BASE_W     = 9;
  localparam int RESP_WORDS = 2;

  localparam logic [ADDR_W-1:0] CTRL_OFS = 12'h050;
  localparam logic [ADDR_W-1:0] STAT_OFS = 12'h054;
  localparam logic [ADDR_W-1:0] ICLR_OFS = 12'h058;

  localparam int REQ_BIT   = 0;
  localparam int BUSY_BIT  = 1;
  localparam int ABORT_BIT = 2;
  localparam int NOTE_BIT  = 3;
  localparam int OP_LSB    = 16;
  localparam int BASE_LSB  = OP_LSB + OP_W;

  // strobes from control to datapath
  typedef struct packed {
    logic              hostWe;
    logic              rspWe;
    logic [BASE_W-1:0] rspBase;
    logic [OP_W-1:0]   rspOp;
  } dpCmd_t;
endpackage

// File: rtl/mboxCtrl.sv
module mboxCtrl
  import mbox_pkg::*;
#(
  parameter int LATENCY = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output dpCmd_t            dpCmd,
  output logic [31:0]       ctrlView,
  output logic [31:0]       statView,
  output logic              busy,
  output logic              reqPend,
  output logic              abortSt,
  output logic              irq
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [OP_W-1:0]   opQ;
  logic [BASE_W-1:0] baseQ;
  logic              noteQ;
  logic [CNT_W-1:0]  cnt;

  logic ctrlHit, clrHit, newReq, abortReq, done;

  assign ctrlHit  = regWe && (regAddr == CTRL_OFS);
  assign clrHit   = regWe && (regAddr == ICLR_OFS) && (regWdata == 32'd0);
  assign newReq   = ctrlHit && regWdata[REQ_BIT] && !busy && !reqPend;
  assign abortReq = ctrlHit && regWdata[ABORT_BIT] && busy;
  assign done     = busy && (cnt == '0) && !abortReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPend <= 1'b0;
      busy    <= 1'b0;
      abortSt <= 1'b0;
      irq     <= 1'b0;
      noteQ   <= 1'b0;
      opQ     <= '0;
      baseQ   <= '0;
      cnt     <= '0;
    end else begin
      if (newReq) begin
        reqPend <= 1'b1;
        opQ     <= regWdata[OP_LSB +: OP_W];
        baseQ   <= regWdata[BASE_LSB +: BASE_W];
        noteQ   <= regWdata[NOTE_BIT];
        abortSt <= 1'b0;
      end
      if (reqPend) begin
        reqPend <= 1'b0;
        busy    <= 1'b1;
        cnt     <= CNT_W'(LATENCY - 1);
      end else if (abortReq) begin
        busy    <= 1'b0;
        abortSt <= 1'b1;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
      if ((abortReq || done) && noteQ) irq <= 1'b1;
      else if (clrHit)                 irq <= 1'b0;
    end
  end

  always_comb begin
    dpCmd.hostWe  = regWe && !busy && !reqPend;
    dpCmd.rspWe   = done;
    dpCmd.rspBase = baseQ;
    dpCmd.rspOp   = opQ;
  end

  assign ctrlView = {baseQ, opQ, 12'd0, noteQ, 1'b0, busy, reqPend};
  assign statView = {28'd0, irq, abortSt, busy, reqPend};
endmodule

// File: rtl/mboxData.sv
module mboxData
  import mbox_pkg::*;
#(
  parameter int BUF_WORDS = 64
) (
  input  logic              clk,
  input  dpCmd_t            dpCmd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  input  logic [3:0]        regBe,
  input  logic [31:0]       ctrlView,
  input  logic [31:0]       statView,
  output logic [31:0]       regRdata
);
  localparam int IDX_W = $clog2(BUF_WORDS);
  localparam logic [9:0] WORD_LIM = 10'(BUF_WORDS);

  logic [31:0] mem [BUF_WORDS];

  logic             bufHit;
  logic [IDX_W-1:0] hostIdx, rspIdx0, rspIdx1;

  assign bufHit  = regAddr[11] && ({1'b0, regAddr[10:2]} < WORD_LIM);
  assign hostIdx = regAddr[IDX_W+1:2];
  assign rspIdx0 = dpCmd.rspBase[IDX_W-1:0];
  assign rspIdx1 = rspIdx0 + 1'b1;

  always_ff @(posedge clk) begin
    if (dpCmd.rspWe) begin
      mem[rspIdx0] <= 32'(dpCmd.rspOp);
      mem[rspIdx1] <= 32'(RESP_WORDS);
    end else if (dpCmd.hostWe && bufHit) begin
      for (int b = 0; b < 4; b++) begin
        if (regBe[b]) mem[hostIdx][8*b +: 8] <= regWdata[8*b +: 8];
      end
    end
  end

  always_comb begin
    regRdata = 32'd0;
    if (regAddr == CTRL_OFS)      regRdata = ctrlView;
    else if (regAddr == STAT_OFS) regRdata = statView;
    else if (bufHit)              regRdata = mem[hostIdx];
  end
endmodule

// File: rtl/svcMailbox.sv
module svcMailbox
  import mbox_pkg::*;
#(
  parameter int BUF_WORDS = 64,
  parameter int LATENCY   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  input  logic [3:0]        regBe,
  output logic [31:0]       regRdata,
  output logic              irq
);
  dpCmd_t      dpCmd;
  logic [31:0] ctrlView, statView;
  logic        busy, reqPend, abortSt;

  mboxCtrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .dpCmd(dpCmd), .ctrlView(ctrlView),
    .statView(statView), .busy(busy), .reqPend(reqPend),
    .abortSt(abortSt), .irq(irq)
  );

  mboxData #(.BUF_WORDS(BUF_WORDS)) u_data (
    .clk(clk), .dpCmd(dpCmd), .regAddr(regAddr), .regWdata(regWdata),
    .regBe(regBe), .ctrlView(ctrlView), .statView(statView),
    .regRdata(regRdata)
  );
endmodule

// File: rtl/mboxChecker.sv
module mboxChecker
  import mbox_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWdata,
  input logic              busy,
  input logic              reqPend,
  input logic              abortSt,
  input logic              irq
);
  // R3
  reqSelfClear_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqPend |=> (!reqPend && busy));

  // R7
  refuseBusy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWe && regAddr == CTRL_OFS && regWdata[REQ_BIT]) |=> !reqPend);

  // R10
  abortEnd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWe && regAddr == CTRL_OFS && regWdata[ABORT_BIT]) |=> (!busy && abortSt));

  // R9
  irqHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(regWe && regAddr == ICLR_OFS && regWdata == 32'd0)) |=> irq);

  // R9
  irqClear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !busy && regWe && regAddr == ICLR_OFS && regWdata == 32'd0) |=> !irq);

  // R8
  irqRise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(busy) && !busy));
endmodule

bind svcMailbox mboxChecker u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .busy(busy), .reqPend(reqPend),
  .abortSt(abortSt), .irq(irq)
);

// File: tb/svcMailbox_bench.sv
module svcMailbox_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 64;
  localparam int LAT = 8;
  localparam logic [11:0] A_CTRL = 12'h050;
  localparam logic [11:0] A_STAT = 12'h054;
  localparam logic [11:0] A_ICLR = 12'h058;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [3:0]  regBe = '0;
  logic [31:0] regRdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  svcMailbox #(.BUF_WORDS(WORDS), .LATENCY(LAT)) u_svcMailbox (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regBe(regBe), .regRdata(regRdata), .irq(irq)
  );

  function automatic logic [11:0] bufAddr(input int i);
    return 12'h800 + 12'(4 * i);
  endfunction

  function automatic logic [31:0] reqWord(input logic [6:0] op, input logic [8:0] base,
                                          input logic note);
    return {base, op, 12'd0, note, 3'b001};
  endfunction

  function automatic logic [31:0] mergeBytes(input logic [31:0] old, input logic [31:0] d,
                                             input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    regAddr = a; regWdata = d; regBe = be; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int k = 0; k < 100; k++) begin
      rd(A_STAT, s);
      if (!s[1]) break;
      @(negedge clk);
    end
  endtask

  task automatic checkWord(input string req, input int i);
    logic [31:0] v;
    rd(bufAddr(i), v);
    chk(req, v, model[i]);
  endtask

  task automatic runSvc(input logic [6:0] op, input logic [5:0] base, input logic note);
    logic [31:0] v;
    int n;
    wr(A_CTRL, reqWord(op, {3'b0, base}, note), 4'hF);
    rd(A_CTRL, v);
    chk("R3 ctrl readback with request", v, reqWord(op, {3'b0, base}, note));
    @(negedge clk);
    rd(A_STAT, v);
    chk("R3 request cleared, busy set", {28'd0, v[3:0]}, 32'h2);
    n = 1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      rd(A_STAT, v);
      if (!v[1]) break;
      n++;
    end
    chk("R4 busy length", 32'(n), 32'(LAT));
    chk("R8 irq vs notify", {31'd0, irq}, {31'd0, note});
    chk("R8 status notify mirrors irq", {31'd0, v[3]}, {31'd0, note});
    model[base] = {25'd0, op};
    model[(int'(base) + 1) % WORDS] = 32'd2;
    checkWord("R5 response opcode word", int'(base));
    checkWord("R5 response count word", (int'(base) + 1) % WORDS);
    checkWord("R5 neighbour untouched", (int'(base) + 2) % WORDS);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, d;
    logic [3:0]  be;
    int idx;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl after reset", v, 32'd0);
    rd(A_STAT, v); chk("R1 status after reset", v, 32'd0);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);

    // R10 abort with nothing running
    wr(A_CTRL, 32'h4, 4'hF);
    rd(A_STAT, v); chk("R10 idle abort ignored", v, 32'd0);
    rd(12'h05C, v); chk("R2 unmapped reads zero", v, 32'd0);

    // R2 R6 fill and read back
    for (int i = 0; i < WORDS; i++) begin
      d = $urandom;
      wr(bufAddr(i), d, 4'hF);
      model[i] = d;
    end
    for (int i = 0; i < WORDS; i++) checkWord("R2 buffer readback", i);

    // R6 partial writes
    for (int k = 0; k < 16; k++) begin
      idx = int'($urandom % WORDS);
      d = $urandom;
      be = 4'($urandom);
      wr(bufAddr(idx), d, be);
      model[idx] = mergeBytes(model[idx], d, be);
      checkWord("R6 byte lane merge", idx);
    end

    // directed request with notify
    runSvc(7'h55, 6'd5, 1'b1);
    wr(A_ICLR, 32'h1, 4'hF);
    chk("R9 nonzero clear keeps irq", {31'd0, irq}, 32'd1);
    wr(A_ICLR, 32'h0, 4'hF);
    chk("R9 zero clear drops irq", {31'd0, irq}, 32'd0);

    // R5 wrap at top of buffer
    runSvc(7'h7F, 6'd63, 1'b0);

    // random requests
    for (int k = 0; k < 8; k++) begin
      runSvc(7'($urandom), 6'($urandom), 1'($urandom));
      wr(A_ICLR, 32'h0, 4'hF);
    end

    // R7 refusal while busy
    wr(A_CTRL, reqWord(7'h21, 9'd10, 1'b0), 4'hF);
    @(negedge clk);
    wr(A_CTRL, reqWord(7'h33, 9'd20, 1'b1), 4'hF);
    wr(bufAddr(30), 32'hDEADBEEF, 4'hF);
    rd(A_CTRL, v);
    chk("R7 latched fields kept", v[31:16], {16'd0, 9'd10, 7'h21} & 32'hFFFF);
    waitIdle();
    model[10] = 32'h21;
    model[11] = 32'd2;
    checkWord("R7 buffer write ignored", 30);
    checkWord("R7 original opcode served", 10);
    checkWord("R7 refused offset untouched", 20);
    chk("R8 no notify no irq", {31'd0, irq}, 32'd0);

    // R10 abort while busy
    wr(A_CTRL, reqWord(7'h44, 9'd40, 1'b1), 4'hF);
    @(negedge clk);
    wr(A_CTRL, 32'h4, 4'hF);
    rd(A_STAT, v); chk("R10 abort status", v, 32'hC);
    chk("R10 abort raises irq", {31'd0, irq}, 32'd1);
    repeat (LAT + 2) @(negedge clk);
    rd(A_STAT, v); chk("R10 stays idle after abort", {31'd0, v[1]}, 32'd0);
    checkWord("R10 no response word", 40);
    checkWord("R10 no count word", 41);
    wr(A_ICLR, 32'h0, 4'hF);
    runSvc(7'h12, 6'd50, 1'b0);
    rd(A_STAT, v); chk("R10 abort cleared by new request", {31'd0, v[2]}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule